// File: doc/BRIEF.md
# Reorder Buffer with Architectural Pointer Commit

This block keeps in-flight instructions in program order for a core whose physical and architectural register values share a single unified register file. Decode places one entry at a time at the tail of a circular buffer and receives the slot index. Each entry records three things: whether the instruction writes a register, the physical register chosen for the result, and the physical register that the same architectural register pointed to before. Writeback later marks the entry complete using that slot index.

The oldest entry retires once it is complete. Retiring a register-writing instruction does not copy any data. It writes the new physical pointer into an architectural map table and hands the previous physical register back to the free list. By that point no older reader can still need the freed register. During that cycle the retire port also carries the architectural destination, so the speculative rename stage can drop its pending mark for that destination.

Top module: `rob_map_commit`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `commit_valid` is 0, and the architectural map sends every architectural register i to physical register i.
- R2: Each accepted allocation returns the current tail index on `alloc_idx` in the same cycle. Successive indices are 0, 1, 2 and so on, modulo DEPTH.
- R3: With DEPTH entries outstanding, `alloc_ready` is 0 and a request on `alloc_valid` is ignored. It creates no entry and does not advance the tail.
- R4: The oldest entry is presented on the retire port only when its completion flag is set. An incomplete oldest entry holds back younger complete entries.
- R5: At most one entry retires per clock. Complete entries retire in consecutive cycles in allocation order, and the port shows that entry's write flag, architectural register and new physical register.
- R6: When an entry with the write flag retires, `free_valid` is 1 with `free_preg` equal to its previous physical register in that cycle. From the next cycle on, the map entry for its architectural register holds its new physical register.
- R7: When an entry without the write flag retires, `free_valid` stays 0 and the architectural map is unchanged.
- R8: A writeback pulse with index k marks entry k complete. Entries retire in allocation order whatever order the writebacks arrive in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests a new entry |
| alloc_wen | input | 1 | Instruction writes a register |
| alloc_areg | input | $clog2(NAREG) | Architectural destination |
| alloc_preg | input | $clog2(NPREG) | Newly assigned physical register |
| alloc_ppreg | input | $clog2(NPREG) | Previous physical register of that destination |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | $clog2(DEPTH) | Slot index given to the request |
| wb_valid | input | 1 | Writeback marks an entry complete |
| wb_idx | input | $clog2(DEPTH) | Slot index being completed |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_wen | output | 1 | Retiring entry writes a register |
| commit_areg | output | $clog2(NAREG) | Architectural destination of the retiring entry |
| commit_preg | output | $clog2(NPREG) | Physical register of the retiring entry |
| free_valid | output | 1 | A physical register returns to the free list |
| free_preg | output | $clog2(NPREG) | Register being freed |
| arch_areg | input | $clog2(NAREG) | Architectural map read address |
| arch_preg | output | $clog2(NPREG) | Architectural map read data |

## Verification
The bench builds the block with DEPTH=4, NAREG=8 and NPREG=16. With four slots, a short burst of allocations fills the buffer, so the stall and an ignored request can be exercised. The pointers then wrap back to slot 0 after a drain. The eight-entry map is small enough to read back in full after reset and after retirement. Completing slots out of order within those four entries shows the oldest entry blocking the others, and then a burst of back-to-back retirements once it completes.

// File: rtl/rob_map_commit.sv
module rob_map_commit #(
  parameter int DEPTH = 4,
  parameter int NAREG = 8,
  parameter int NPREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  input  logic                     alloc_wen,
  input  logic [$clog2(NAREG)-1:0] alloc_areg,
  input  logic [$clog2(NPREG)-1:0] alloc_preg,
  input  logic [$clog2(NPREG)-1:0] alloc_ppreg,
  output logic                     alloc_ready,
  output logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  output logic                     commit_valid,
  output logic                     commit_wen,
  output logic [$clog2(NAREG)-1:0] commit_areg,
  output logic [$clog2(NPREG)-1:0] commit_preg,
  output logic                     free_valid,
  output logic [$clog2(NPREG)-1:0] free_preg,
  input  logic [$clog2(NAREG)-1:0] arch_areg,
  output logic [$clog2(NPREG)-1:0] arch_preg
);
  localparam int IW = $clog2(DEPTH);
  localparam int AW = $clog2(NAREG);
  localparam int PW = $clog2(NPREG);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] vld, done, wen;
  logic [AW-1:0]    areg_q  [DEPTH];
  logic [PW-1:0]    preg_q  [DEPTH];
  logic [PW-1:0]    ppreg_q [DEPTH];
  logic [PW-1:0]    amap    [NAREG];

  wire alloc_fire = alloc_valid && alloc_ready;

  assign alloc_ready  = (count != CW'(DEPTH));
  assign alloc_idx    = tail;
  assign commit_valid = vld[head] && done[head];
  assign commit_wen   = wen[head];
  assign commit_areg  = areg_q[head];
  assign commit_preg  = preg_q[head];
  assign free_valid   = commit_valid && wen[head];
  assign free_preg    = ppreg_q[head];
  assign arch_preg    = amap[arch_areg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      vld   <= '0;
      done  <= '0;
    end else begin
      if (commit_valid) begin
        vld[head] <= 1'b0;
        head      <= head + 1'b1;
      end
      if (alloc_fire) begin
        vld[tail]  <= 1'b1;
        done[tail] <= 1'b0;
        tail       <= tail + 1'b1;
      end
      if (wb_valid && vld[wb_idx])
        done[wb_idx] <= 1'b1;
      count <= count + CW'(alloc_fire) - CW'(commit_valid);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      wen[tail]     <= alloc_wen;
      areg_q[tail]  <= alloc_areg;
      preg_q[tail]  <= alloc_preg;
      ppreg_q[tail] <= alloc_ppreg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NAREG; i++) amap[i] <= PW'(i);
    end else if (free_valid) begin
      amap[commit_areg] <= commit_preg;
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |=> tail == $past(tail));

  a_r2_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> tail == $past(tail) + 1'b1);

  a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head == $past(head) + 1'b1);

  a_r4_head_waits: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |=> head == $past(head));

  a_r6_map_write: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> amap[$past(commit_areg)] == $past(commit_preg));

  a_r7_map_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_wen) |=> amap[$past(commit_areg)] == $past(amap[commit_areg]));
endmodule

// File: tb/tb_rob_map_commit.sv
module tb_rob_map_commit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_wen = 1'b0;
  logic [2:0] alloc_areg = '0;
  logic [3:0] alloc_preg = '0, alloc_ppreg = '0;
  logic alloc_ready;
  logic [1:0] alloc_idx;
  logic wb_valid = 1'b0;
  logic [1:0] wb_idx = '0;
  logic commit_valid, commit_wen, free_valid;
  logic [2:0] commit_areg;
  logic [3:0] commit_preg, free_preg;
  logic [2:0] arch_areg = '0;
  logic [3:0] arch_preg;

  int tests = 0, fails = 0;
  logic [11:0] expq[$];

  always #2 clk = ~clk;

  rob_map_commit #(.DEPTH(4), .NAREG(8), .NPREG(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_wen(alloc_wen), .alloc_areg(alloc_areg),
    .alloc_preg(alloc_preg), .alloc_ppreg(alloc_ppreg),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx),
    .commit_valid(commit_valid), .commit_wen(commit_wen),
    .commit_areg(commit_areg), .commit_preg(commit_preg),
    .free_valid(free_valid), .free_preg(free_preg),
    .arch_areg(arch_areg), .arch_preg(arch_preg));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic alloc(input logic w, input logic [2:0] a, input logic [3:0] p,
                       input logic [3:0] pp, input int exp_idx);
    alloc_valid = 1'b1; alloc_wen = w; alloc_areg = a;
    alloc_preg = p; alloc_ppreg = pp;
    #1;
    check("R2 alloc_ready", int'(alloc_ready), 1);
    check("R2 alloc_idx", int'(alloc_idx), exp_idx);
    if (alloc_ready) expq.push_back({w, a, p, pp});
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic wb(input logic [1:0] k);
    wb_valid = 1'b1; wb_idx = k;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic map_is(input int a, input int p, input string req);
    arch_areg = 3'(a);
    #1;
    check(req, int'(arch_preg), p);
  endtask

  // monitor: compare each retirement with the scoreboard head (R5, R6, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      if (commit_valid) begin
        if (expq.size() == 0) begin
          tests++; fails++;
          $display("FAIL R5: unexpected retire actual areg %0d expected none", commit_areg);
        end else begin
          logic [11:0] e;
          e = expq.pop_front();
          check("R5 commit_wen", int'(commit_wen), int'(e[11]));
          check("R5 commit_areg", int'(commit_areg), int'(e[10:8]));
          check("R5 commit_preg", int'(commit_preg), int'(e[7:4]));
          if (e[11]) begin
            check("R6 free_valid", int'(free_valid), 1);
            check("R6 free_preg", int'(free_preg), int'(e[3:0]));
          end else begin
            check("R7 free_valid", int'(free_valid), 0);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 alloc_ready", int'(alloc_ready), 1);
    check("R1 commit_valid", int'(commit_valid), 0);
    for (int a = 0; a < 8; a++) map_is(a, a, "R1 map identity");
    @(negedge clk);

    alloc(1'b1, 3'd1, 4'd8, 4'd1, 0);
    alloc(1'b1, 3'd2, 4'd9, 4'd2, 1);
    alloc(1'b0, 3'd5, 4'd11, 4'd5, 2);
    alloc(1'b1, 3'd1, 4'd10, 4'd8, 3);

    // R3: buffer full, request must be ignored
    alloc_valid = 1'b1; alloc_wen = 1'b1; alloc_areg = 3'd6;
    alloc_preg = 4'd13; alloc_ppreg = 4'd6;
    #1;
    check("R3 alloc_ready full", int'(alloc_ready), 0);
    @(negedge clk);
    alloc_valid = 1'b0;

    // R8/R4: complete younger entries first
    wb(2'd1);
    #1; check("R4 blocked after wb1", int'(commit_valid), 0);
    wb(2'd3);
    wb(2'd2);
    #1; check("R4 blocked after wb3 wb2", int'(commit_valid), 0);
    check("R3 still full", int'(alloc_ready), 0);
    wb(2'd0);
    for (int k = 0; k < 4; k++) begin
      #1; check("R5 back-to-back retire", int'(commit_valid), 1);
      @(negedge clk);
    end
    #1;
    check("R5 drained", int'(commit_valid), 0);
    check("R8 all retired", expq.size(), 0);
    check("R3 ready after drain", int'(alloc_ready), 1);

    map_is(1, 10, "R6 map areg1");
    map_is(2, 9, "R6 map areg2");
    map_is(5, 5, "R7 map areg5 unchanged");
    map_is(6, 6, "R3 ignored request left map");
    @(negedge clk);

    // R2/R3: wrap to slot 0, proving the ignored request did not advance the tail
    alloc(1'b1, 3'd3, 4'd12, 4'd3, 0);
    wb(2'd0);
    @(negedge clk);
    #1;
    map_is(3, 12, "R6 map areg3");
    check("R5 empty again", int'(commit_valid), 0);
    check("R8 queue empty", expq.size(), 0);
    finish_up();
  end
endmodule